// File: doc/BRIEF.md
# Indexed Configuration Register File

This block places a small set of processor configuration and identification registers behind a pair of I/O ports. Software first writes a register number to the index port and then makes a single read or write at the data port; that data access reaches the selected register. Every data access needs its own preceding index write. A data access that has no index write in front of it is dropped.

The file holds two writable control registers and two constant identification bytes. The first control register, the extension gate, is always reachable. Its upper nibble decides whether the second control register, the feature register, can be reached at all. Bit 7 of the feature register drives an output that enables the processor's identification instruction. The identification bytes return a model/stepping code and a revision code that are fixed by parameters.

Read data is registered. It appears on `io_rdata` in the cycle after the read strobe and holds there until the next read strobe.

Top module: `cfgx_index_port`

## Requirements
- R1: While `rst_n` is low, `io_rdata` is FFh and `id_insn_en` is 0. After reset, both control registers read 00h once they are reachable.
- R2: A read strobe at the data port (address 23h) that follows an index write places the selected register on `io_rdata` one clock later. `io_rdata` does not change in any cycle without a read strobe.
- R3: A data-port access with no index write since the last data-port access is ignored. A write of this kind changes nothing, and a read of this kind returns FFh.
- R4: An index write at address 22h arms exactly one data-port access. A second data access without a new index write behaves as in R3.
- R5: Index FFh reads the model/stepping byte (parameter, default 1Bh) and index FEh reads the revision byte (parameter, default 05h). Writes to either index have no effect.
- R6: Index C3h holds the extension gate. All 8 bits can be read and written at any time.
- R7: The feature register at index E8h is reachable only while the upper nibble of the extension gate (bits 7..4) equals 0001b. Otherwise writes to it are dropped and reads of it return FFh.
- R8: Bit 7 of the feature register drives `id_insn_en`. The output changes in the cycle after an accepted write and at no other time.
- R9: A data access to any index other than C3h, E8h, FEh or FFh writes nothing and reads FFh.
- R10: When read and write strobes are both asserted at the data port in one armed cycle, the read returns the contents from before the write, the write takes effect, and only one armed access is used up.
- R11: A read at any address other than 23h returns FFh. Accesses at addresses other than 22h and 23h do not change the index or the armed state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| id_insn_en | output | 1 | Identification instruction enable (bit 7 of the feature register) |

## Verification
Two functions can land on the same edge. The first pair is a read and a write of one register through a single armed data access. The second pair is a write to the extension gate and the gating check that the next feature-register access depends on. The bench drives both strobes together on an armed gate access. It expects the old byte on `io_rdata`, the new byte on a later read, and a disarmed port afterwards. It also flips the gate nibble between accesses to the feature register. At every clock it compares `io_rdata` and `id_insn_en` against a behavioural model that applies reads before writes.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t SLOT_GATE   = 8'hC3;
  localparam byte_t SLOT_FEAT   = 8'hE8;
  localparam byte_t SLOT_REV    = 8'hFE;
  localparam byte_t SLOT_MODEL  = 8'hFF;
  localparam byte_t IDLE_BYTE   = 8'hFF;

  localparam int    FEAT_ID_BIT = 7;
  localparam logic [3:0] UNLOCK_CODE = 4'b0001;

  function automatic logic gate_open(input byte_t gate);
    return gate[BYTE_W-1 -: 4] == UNLOCK_CODE;
  endfunction
endpackage

// File: rtl/cfgx_port_decode.sv
module cfgx_port_decode
  import cfgx_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'h23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  byte_t             io_wdata,
  output byte_t             sel_slot,
  output logic              acc_rd,
  output logic              acc_wr
);
  byte_t slot_q, slot_d;
  logic  armed_q, armed_d;
  logic  hit_index, hit_data, slot_en;

  assign hit_index = (io_addr == INDEX_PORT);
  assign hit_data  = (io_addr == DATA_PORT);

  always_comb begin
    slot_d  = slot_q;
    armed_d = armed_q;
    slot_en = 1'b0;
    acc_rd  = 1'b0;
    acc_wr  = 1'b0;
    if (io_wr && hit_index) begin
      slot_d  = io_wdata;
      slot_en = 1'b1;
      armed_d = 1'b1;
    end
    if (hit_data && (io_rd || io_wr)) begin
      acc_rd  = io_rd && armed_q;
      acc_wr  = io_wr && armed_q;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (slot_en) slot_q <= slot_d;
    end
  end

  assign sel_slot = slot_q;
endmodule

// File: rtl/cfgx_reg_bank.sv
module cfgx_reg_bank
  import cfgx_pkg::*;
#(
  parameter byte_t MODEL_ID = 8'h1B,
  parameter byte_t REV_ID   = 8'h05
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t sel_slot,
  input  logic  acc_wr,
  input  byte_t wdata,
  output byte_t rd_val,
  output logic  id_insn_en
);
  byte_t gate_q, feat_q;
  logic  gate_en, feat_en, open;

  assign open = gate_open(gate_q);

  always_comb begin
    gate_en = acc_wr && (sel_slot == SLOT_GATE);
    feat_en = acc_wr && (sel_slot == SLOT_FEAT) && open;
  end

  always_comb begin
    unique case (sel_slot)
      SLOT_GATE:  rd_val = gate_q;
      SLOT_FEAT:  rd_val = open ? feat_q : IDLE_BYTE;
      SLOT_REV:   rd_val = REV_ID;
      SLOT_MODEL: rd_val = MODEL_ID;
      default:    rd_val = IDLE_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      feat_q <= '0;
    end else begin
      if (gate_en) gate_q <= wdata;
      if (feat_en) feat_q <= wdata;
    end
  end

  assign id_insn_en = feat_q[FEAT_ID_BIT];
endmodule

// File: rtl/cfgx_index_port.sv
module cfgx_index_port
  import cfgx_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'h23,
  parameter logic [7:0]        MODEL_ID   = 8'h1B,
  parameter logic [7:0]        REV_ID     = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              id_insn_en
);
  byte_t sel_slot, rd_val, rdata_q, rdata_d;
  logic  acc_rd, acc_wr;

  cfgx_port_decode #(
    .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) decode_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .sel_slot(sel_slot),
    .acc_rd(acc_rd), .acc_wr(acc_wr)
  );

  cfgx_reg_bank #(
    .MODEL_ID(MODEL_ID), .REV_ID(REV_ID)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .sel_slot(sel_slot), .acc_wr(acc_wr),
    .wdata(io_wdata), .rd_val(rd_val), .id_insn_en(id_insn_en)
  );

  always_comb begin
    rdata_d = acc_rd ? rd_val : IDLE_BYTE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= IDLE_BYTE;
    else if (io_rd) rdata_q <= rdata_d;
  end

  assign io_rdata = rdata_q;
endmodule

// File: rtl/cfgx_index_port_chk.sv
module cfgx_index_port_chk #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'h23
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_rdata,
  input logic              id_insn_en
);
  logic seen_index;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_index <= 1'b0;
    else if (io_wr && io_addr == INDEX_PORT) seen_index <= 1'b1;
    else if ((io_rd || io_wr) && io_addr == DATA_PORT) seen_index <= 1'b0;
  end

  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  a_r3_unarmed_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == DATA_PORT && !seen_index) |=> io_rdata == 8'hFF);

  a_r11_other_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr != DATA_PORT) |=> io_rdata == 8'hFF);

  a_r8_enable_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == DATA_PORT && seen_index) |=> $stable(id_insn_en));
endmodule

bind cfgx_index_port cfgx_index_port_chk #(
  .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
  .io_wr(io_wr), .io_rdata(io_rdata), .id_insn_en(id_insn_en)
);

// File: tb/cfgx_index_port_tb_top.sv
`timescale 1ns/1ps
module cfgx_index_port_tb_top;
  localparam logic [15:0] IXP = 16'h0022;
  localparam logic [15:0] DTP = 16'h0023;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        id_insn_en;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_gate = 0, m_feat = 0, m_slot = 0;
  bit m_armed = 0;
  int m_rdata = 8'hFF;

  always #2.5 clk = ~clk;

  cfgx_index_port dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .id_insn_en(id_insn_en)
  );

  function automatic int model_read();
    bit open = ((m_gate >> 4) & 15) == 1;
    case (m_slot)
      8'hC3: return m_gate;
      8'hE8: return open ? m_feat : 8'hFF;
      8'hFE: return 8'h05;
      8'hFF: return 8'h1B;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic compare();
    vectors++;
    if (io_rdata !== m_rdata[7:0]) begin
      miscompares++;
      $display("FAIL %s io_rdata actual=%02h expected=%02h", cur_req, io_rdata, m_rdata[7:0]);
    end
    vectors++;
    if (id_insn_en !== m_feat[7]) begin
      miscompares++;
      $display("FAIL %s id_insn_en actual=%0b expected=%0b", cur_req, id_insn_en, m_feat[7]);
    end
  endtask

  task automatic step(input logic [15:0] a, input bit rd, input bit wr, input int wd);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = wd[7:0];
    @(posedge clk);
    begin
      bit open = ((m_gate >> 4) & 15) == 1;
      int rv = 8'hFF;
      if (rd && a == DTP && m_armed) rv = model_read();
      if (rd) m_rdata = rv;
      if (wr && a == IXP) begin m_slot = wd & 255; m_armed = 1; end
      else if (wr && a == DTP && m_armed) begin
        if (m_slot == 8'hC3) m_gate = wd & 255;
        else if (m_slot == 8'hE8 && open) m_feat = wd & 255;
      end
      if (a == DTP && (rd || wr)) m_armed = 0;
    end
    @(negedge clk);
    io_rd = 0; io_wr = 0;
    compare();
  endtask

  task automatic sel(input int s);  step(IXP, 0, 1, s); endtask
  task automatic rd_at(input int s); sel(s); step(DTP, 1, 0, 0); endtask
  task automatic wr_at(input int s, input int v); sel(s); step(DTP, 0, 1, v); endtask

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1"; compare();
    rst_n = 1'b1;
    @(negedge clk); compare();

    cur_req = "R3"; step(DTP, 1, 0, 0);        // unarmed read -> FF
    step(DTP, 0, 1, 8'h77);                    // unarmed write dropped
    cur_req = "R1"; rd_at(8'hC3);              // gate 00h after reset

    cur_req = "R5"; rd_at(8'hFF); rd_at(8'hFE);
    wr_at(8'hFF, 8'h00); wr_at(8'hFE, 8'hAA); rd_at(8'hFF); rd_at(8'hFE);

    cur_req = "R2"; step(DTP, 0, 0, 0); step(16'h0000, 0, 0, 0);
    cur_req = "R6"; wr_at(8'hC3, 8'hA5); rd_at(8'hC3);

    cur_req = "R7"; wr_at(8'hE8, 8'h80); rd_at(8'hE8);
    wr_at(8'hC3, 8'h01); wr_at(8'hE8, 8'h80); rd_at(8'hE8);
    wr_at(8'hC3, 8'h1F); rd_at(8'hE8);        // still 00h: earlier write dropped
    cur_req = "R8"; wr_at(8'hE8, 8'h80); rd_at(8'hE8);
    wr_at(8'hE8, 8'h7F); wr_at(8'hE8, 8'hC1);

    cur_req = "R4"; sel(8'hC3); step(DTP, 1, 0, 0); step(DTP, 1, 0, 0);
    sel(8'hE8); step(DTP, 0, 1, 8'h00); step(DTP, 0, 1, 8'h00); rd_at(8'hE8);

    cur_req = "R9"; wr_at(8'h50, 8'h12); rd_at(8'h50); rd_at(8'h00);

    cur_req = "R10"; sel(8'hC3); step(DTP, 1, 1, 8'h13); step(DTP, 1, 0, 0); rd_at(8'hC3);

    cur_req = "R11"; sel(8'hC3); step(IXP, 1, 0, 0); step(16'h0123, 1, 1, 8'h55);
    step(16'h0122, 0, 1, 8'hFE); step(DTP, 1, 0, 0);

    cur_req = "R7"; wr_at(8'hC3, 8'h20); rd_at(8'hE8); wr_at(8'hE8, 8'h00); rd_at(8'hC3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule